// File: doc/BRIEF.md
# Speaker fault diagnostic sequencer

This block sequences the fault diagnostics of a two-channel bridge speaker amplifier. Per channel, it receives digitised comparator flags: short to ground, short to supply, shorted load, open load, output offset beyond threshold, and short-circuit protection tripped. From these it drives the turn-on test-current pulse, the power-stage bias and the shutdown of each channel. It also keeps two readable status bytes that a bus slave shifts out.

At power-up with diagnostics enabled, a turn-on window runs while the output stage is still unbiased. After that the amplifier is biased and permanent supervision takes over. In permanent supervision, an overload first passes a short glitch filter. If the overload persists, it escalates to a full diagnostic window. A separate offset test measures across the interval between bus reads. Each result is reported only when its flag held for the whole window.

A completed cycle is not repeated until a bus read re-arms the sequencer. The bytes therefore always show the last completed window. Timings are counted in ticks from a parameterised divider, so a bench can shrink them.

Top module: `spkdiag_seq`

## Requirements
- R1: After reset, `pulse_en`, `bias_en`, `ch_off`, `db1` and `db2` are all zero.
- R2: The status byte layouts are fixed.
  - `db1` = {thermal, done, 0, ch0[4:0]} and `db2` = {offset-active, 0, 0, ch1[4:0]}.
  - Each channel field holds [4] permanent (1) or turn-on (0) result, [3] shorted load, [2] open load or offset, [1] short to supply and [0] short to ground.
- R3: Raising `amp_on` while `diag_en` is set and the sequencer is armed starts a turn-on window.
  - For `CYC_MS` ticks, `pulse_en` is 1 and `bias_en` is 0.
  - `bias_en` then rises and both fields are latched with bit 4 cleared.
- R4: Raising `amp_on` with `diag_en` clear, or while disarmed, goes straight to `bias_en`=1 without any pulse.
- R5: When several faults are captured together, only one is reported. Priority is short to ground over short to supply over shorted load over open load (or offset, where bit 2 is set by a permanent window).
- R6: With diagnostics enabled and armed, an overload on a biased channel shuts that channel for `FILT_MS` ticks. If the overload has cleared by then, the channel resumes and the bytes are unchanged.
- R7: If the overload is still present at the end of the filter, a `CYC_MS`-tick diagnostic window runs.
  - At its end the channel field is latched with bit 4 set and bit 2 clear.
  - The channel then stays in restart mode.
- R8: In restart mode the channel stays shut and is re-checked on every tick. It resumes once its overload is gone; no byte changes. Restart mode is used directly when diagnostics are disabled or the sequencer is disarmed.
- R9: Completing any cycle has two effects: it sets `db1` bit 6 and disarms the sequencer. A `rd_done` pulse clears bit 6 and re-arms. Apart from bit 6, bit 7 of each byte and an offset capture, the bytes change only at a cycle end.
- R10: A fault bit is set only if its flag was asserted on every clock of the window. A single-cycle dropout clears it.
- R11: While biased with `offset_en` set, an offset window is active and `db2` bit 7 is 1.
  - The window opens on the rising of `offset_en` and on every `rd_done`; it closes on `rd_done`.
  - At the close, each channel's bit 2 receives the windowed offset result.
- R12: If any channel's protection trips during an open offset window, the close of that window writes 0 to bit 2 of both channels.
- R13: `db1` bit 7 follows `therm_warn` one clock later.
- R14: Dropping `amp_on` returns to standby on the next clock. `bias_en` and `pulse_en` go low, and an unfinished turn-on window is discarded without touching the bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| amp_on | input | 1 | Amplifier power-up request (low = standby) |
| diag_en | input | 1 | Diagnostics enable |
| offset_en | input | 1 | Offset test enable |
| therm_warn | input | 1 | Die temperature warning flag |
| rd_done | input | 1 | One-cycle pulse on each completed bus read |
| f_gnd | input | 2 | Per-channel short-to-ground flag |
| f_vs | input | 2 | Per-channel short-to-supply flag |
| f_sload | input | 2 | Per-channel shorted-load flag |
| f_open | input | 2 | Per-channel open-load flag |
| f_ofs | input | 2 | Per-channel output offset flag |
| f_scp | input | 2 | Per-channel short-circuit protection tripped |
| pulse_en | output | 1 | Turn-on test-current pulse enable |
| bias_en | output | 1 | Power stage biased |
| ch_off | output | 2 | Per-channel shutdown |
| db1 | output | 8 | Status byte 1 |
| db2 | output | 8 | Status byte 2 |

## Verification
The properties assume that `rd_done` is a single-cycle pulse. They also assume the comparator flags are already synchronous to `clk`, so a flag counts as held for a window exactly when it is high on every sampled edge. The stimulus drives every input on the falling clock edge and keeps each fault pattern constant across a window, except where a one-cycle dropout is applied on purpose. `rd_done` is only ever raised for one cycle. `amp_on` is dropped only when no channel overload is active, so the checks on channel shutdown compare states that a biased amplifier can actually reach.

// File: rtl/spkdiag_pkg.sv
package spkdiag_pkg;

    localparam int NCH = 2;

    typedef struct packed {
        logic gnd;
        logic vs;
        logic sload;
        logic open;
        logic ofs;
        logic scp;
    } sense_t;

    // Field order is the byte layout: [4] perm, [3] sload, [2] open/ofs, [1] vs, [0] gnd
    typedef struct packed {
        logic perm;
        logic sload;
        logic d2;
        logic vs;
        logic gnd;
    } chrep_t;

    typedef enum logic [1:0] {PW_OFF, PW_TON, PW_ON} pwr_e;
    typedef enum logic [1:0] {CH_RUN, CH_FILT, CH_DIAG, CH_RESTART} ch_e;

    // Keep only the highest ranked fault of a capture.
    function automatic chrep_t rank_faults(input logic perm, input logic g, input logic v,
                                           input logic s, input logic o);
        chrep_t r;
        r.perm  = perm;
        r.gnd   = g;
        r.vs    = v & ~g;
        r.sload = s & ~g & ~v;
        r.d2    = o & ~g & ~v & ~s;
        return r;
    endfunction

    function automatic logic [7:0] pack_status(input logic b7, input logic b6, input chrep_t r);
        return {b7, b6, 1'b0, r};
    endfunction

endpackage

// File: rtl/spkdiag_tick.sv
module spkdiag_tick #(
    parameter int DIV = 50000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == W'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/spkdiag_ofs.sv
module spkdiag_ofs (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic rd_done,
    input  logic any_scp,
    output logic win,
    output logic start,
    output logic close,
    output logic valid
);
    logic en_d;
    logic cancel;

    assign start = en & (~en_d | rd_done);
    assign close = rd_done & win;
    assign valid = ~cancel;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_d   <= 1'b0;
            win    <= 1'b0;
            cancel <= 1'b0;
        end else begin
            en_d <= en;
            if (!en)        win <= 1'b0;
            else if (start) win <= 1'b1;
            if (start)               cancel <= 1'b0;
            else if (win && any_scp) cancel <= 1'b1;
        end
    end
endmodule

// File: rtl/spkdiag_chan.sv
module spkdiag_chan
    import spkdiag_pkg::*;
#(
    parameter int FILT_MS = 1,
    parameter int CYC_MS  = 100
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   biased,
    input  logic   diag_go,
    input  logic   ton_start,
    input  logic   ton_end,
    input  logic   ofs_start,
    input  logic   ofs_close,
    input  logic   ofs_valid,
    input  sense_t sense,
    output logic   shut,
    output logic   perm_done,
    output chrep_t rep
);
    localparam int MAXMS = (CYC_MS > FILT_MS) ? CYC_MS : FILT_MS;
    localparam int CW    = $clog2(MAXMS + 1);

    ch_e          st;
    logic [CW-1:0] ms;
    logic         s_gnd, s_vs, s_sl, s_op, s_ofs;
    logic         filt_end, diag_end, win_start;

    assign filt_end  = (st == CH_FILT) && tick && (ms == CW'(FILT_MS - 1));
    assign diag_end  = (st == CH_DIAG) && tick && (ms == CW'(CYC_MS - 1));
    assign win_start = ton_start | (filt_end & sense.scp);
    assign shut      = biased && (st != CH_RUN);
    assign perm_done = diag_end;

    always_ff @(posedge clk) begin
        if (rst || !biased) begin
            st <= CH_RUN;
            ms <= '0;
        end else begin
            case (st)
                CH_RUN: begin
                    ms <= '0;
                    if (sense.scp) st <= diag_go ? CH_FILT : CH_RESTART;
                end
                CH_FILT: if (tick) begin
                    if (filt_end) begin
                        st <= sense.scp ? CH_DIAG : CH_RUN;
                        ms <= '0;
                    end else begin
                        ms <= ms + 1'b1;
                    end
                end
                CH_DIAG: if (tick) begin
                    if (diag_end) begin
                        st <= CH_RESTART;
                        ms <= '0;
                    end else begin
                        ms <= ms + 1'b1;
                    end
                end
                default: if (tick && !sense.scp) st <= CH_RUN;
            endcase
        end
    end

    // Windowed sticky AND of each flag
    always_ff @(posedge clk) begin
        if (rst || win_start) begin
            s_gnd <= 1'b1;
            s_vs  <= 1'b1;
            s_sl  <= 1'b1;
            s_op  <= 1'b1;
        end else begin
            s_gnd <= s_gnd & sense.gnd;
            s_vs  <= s_vs  & sense.vs;
            s_sl  <= s_sl  & sense.sload;
            s_op  <= s_op  & sense.open;
        end
        if (rst || ofs_start) s_ofs <= 1'b1;
        else                  s_ofs <= s_ofs & sense.ofs;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rep <= '0;
        end else begin
            if (ton_end)
                rep <= rank_faults(1'b0, s_gnd & sense.gnd, s_vs & sense.vs,
                                   s_sl & sense.sload, s_op & sense.open);
            else if (diag_end)
                rep <= rank_faults(1'b1, s_gnd & sense.gnd, s_vs & sense.vs,
                                   s_sl & sense.sload, 1'b0);
            if (ofs_close)
                rep.d2 <= ofs_valid & s_ofs & sense.ofs;
        end
    end
endmodule

// File: rtl/spkdiag_seq.sv
module spkdiag_seq
    import spkdiag_pkg::*;
#(
    parameter int TICK_DIV = 50000,
    parameter int FILT_MS  = 1,
    parameter int CYC_MS   = 100
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           amp_on,
    input  logic           diag_en,
    input  logic           offset_en,
    input  logic           therm_warn,
    input  logic           rd_done,
    input  logic [NCH-1:0] f_gnd,
    input  logic [NCH-1:0] f_vs,
    input  logic [NCH-1:0] f_sload,
    input  logic [NCH-1:0] f_open,
    input  logic [NCH-1:0] f_ofs,
    input  logic [NCH-1:0] f_scp,
    output logic           pulse_en,
    output logic           bias_en,
    output logic [NCH-1:0] ch_off,
    output logic [7:0]     db1,
    output logic [7:0]     db2
);
    localparam int CW = $clog2(CYC_MS + 1);

    logic          tick;
    pwr_e          pw;
    logic [CW-1:0] ms;
    logic          armed, done, therm_q;
    logic          ton_start, ton_end, cyc_end;
    logic [NCH-1:0] perm_done;
    chrep_t        rep [NCH];
    logic          ofs_win, ofs_start, ofs_close, ofs_valid;

    spkdiag_tick #(.DIV(TICK_DIV)) tick_i (.clk(clk), .rst(rst), .tick(tick));

    assign ton_start = (pw == PW_OFF) && amp_on && diag_en && armed;
    assign ton_end   = (pw == PW_TON) && amp_on && tick && (ms == CW'(CYC_MS - 1));
    assign cyc_end   = ton_end | (|perm_done);
    assign pulse_en  = (pw == PW_TON);
    assign bias_en   = (pw == PW_ON);

    always_ff @(posedge clk) begin
        if (rst) begin
            pw <= PW_OFF;
            ms <= '0;
        end else begin
            case (pw)
                PW_OFF: begin
                    ms <= '0;
                    if (amp_on) pw <= (diag_en && armed) ? PW_TON : PW_ON;
                end
                PW_TON: begin
                    if (!amp_on) pw <= PW_OFF;
                    else if (tick) begin
                        if (ton_end) begin
                            pw <= PW_ON;
                            ms <= '0;
                        end else begin
                            ms <= ms + 1'b1;
                        end
                    end
                end
                default: if (!amp_on) pw <= PW_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b1;
            done    <= 1'b0;
            therm_q <= 1'b0;
        end else begin
            therm_q <= therm_warn;
            if (cyc_end) begin
                armed <= 1'b0;
                done  <= 1'b1;
            end else if (rd_done) begin
                armed <= 1'b1;
                done  <= 1'b0;
            end
        end
    end

    spkdiag_ofs ofs_i (
        .clk(clk), .rst(rst), .en(offset_en & bias_en), .rd_done(rd_done),
        .any_scp(|f_scp), .win(ofs_win), .start(ofs_start), .close(ofs_close),
        .valid(ofs_valid)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        sense_t sn;
        assign sn = '{gnd: f_gnd[c], vs: f_vs[c], sload: f_sload[c],
                      open: f_open[c], ofs: f_ofs[c], scp: f_scp[c]};
        spkdiag_chan #(.FILT_MS(FILT_MS), .CYC_MS(CYC_MS)) chan_i (
            .clk(clk), .rst(rst), .tick(tick), .biased(bias_en),
            .diag_go(diag_en & armed), .ton_start(ton_start), .ton_end(ton_end),
            .ofs_start(ofs_start), .ofs_close(ofs_close), .ofs_valid(ofs_valid),
            .sense(sn), .shut(ch_off[c]), .perm_done(perm_done[c]), .rep(rep[c])
        );
    end

    assign db1 = pack_status(therm_q, done, rep[0]);
    assign db2 = pack_status(ofs_win, 1'b0, rep[1]);
endmodule

// File: rtl/spkdiag_checker.sv
module spkdiag_checker
    import spkdiag_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           amp_on,
    input logic           offset_en,
    input logic           therm_warn,
    input logic           rd_done,
    input logic [NCH-1:0] f_scp,
    input logic           pulse_en,
    input logic           bias_en,
    input logic [NCH-1:0] ch_off,
    input logic [7:0]     db1,
    input logic [7:0]     db2,
    input logic           ton_end,
    input logic [NCH-1:0] perm_done,
    input logic           ofs_close
);
    a_r3_pulse_unbiased: assert property (@(posedge clk) disable iff (rst)
        pulse_en |-> !bias_en);

    a_r14_standby: assert property (@(posedge clk) disable iff (rst)
        !amp_on |=> (!bias_en && !pulse_en));

    a_r9_bytes_hold: assert property (@(posedge clk) disable iff (rst)
        (!ton_end && perm_done == '0 && !ofs_close) |=> ($stable(db1[5:0]) && $stable(db2[4:0])));

    a_r9_end_sets_done: assert property (@(posedge clk) disable iff (rst)
        (ton_end || perm_done != '0) |=> db1[6]);

    a_r9_read_clears_done: assert property (@(posedge clk) disable iff (rst)
        (rd_done && !ton_end && perm_done == '0) |=> !db1[6]);

    a_r13_therm_high: assert property (@(posedge clk) disable iff (rst)
        therm_warn |=> db1[7]);

    a_r13_therm_low: assert property (@(posedge clk) disable iff (rst)
        !therm_warn |=> !db1[7]);

    a_r11_offset_idle: assert property (@(posedge clk) disable iff (rst)
        !offset_en |=> !db2[7]);

    for (genvar c = 0; c < NCH; c++) begin : g_a
        a_r6_shut_on_overload: assert property (@(posedge clk) disable iff (rst)
            (bias_en && amp_on && f_scp[c] && !ch_off[c]) |=> ch_off[c]);
    end
endmodule

bind spkdiag_seq spkdiag_checker chk_i (
    .clk(clk), .rst(rst), .amp_on(amp_on), .offset_en(offset_en),
    .therm_warn(therm_warn), .rd_done(rd_done), .f_scp(f_scp),
    .pulse_en(pulse_en), .bias_en(bias_en), .ch_off(ch_off), .db1(db1), .db2(db2),
    .ton_end(ton_end), .perm_done(perm_done), .ofs_close(ofs_close)
);

// File: tb/spkdiag_seq_tb_top.sv
module spkdiag_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       amp_on = 1'b0, diag_en = 1'b0, offset_en = 1'b0;
    logic       therm_warn = 1'b0, rd_done = 1'b0;
    logic [1:0] f_gnd = '0, f_vs = '0, f_sload = '0, f_open = '0, f_ofs = '0, f_scp = '0;
    logic       pulse_en, bias_en;
    logic [1:0] ch_off;
    logic [7:0] db1, db2;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    typedef struct {
        string      tag;
        int         sel;
        logic [7:0] exp;
    } exp_t;
    exp_t q[$];

    localparam int S_DB1 = 0, S_DB2 = 1, S_PULSE = 2, S_BIAS = 3, S_OFF = 4;

    always #4 clk = ~clk;

    spkdiag_seq #(.TICK_DIV(4), .FILT_MS(2), .CYC_MS(5)) dut_i (
        .clk(clk), .rst(rst), .amp_on(amp_on), .diag_en(diag_en), .offset_en(offset_en),
        .therm_warn(therm_warn), .rd_done(rd_done), .f_gnd(f_gnd), .f_vs(f_vs),
        .f_sload(f_sload), .f_open(f_open), .f_ofs(f_ofs), .f_scp(f_scp),
        .pulse_en(pulse_en), .bias_en(bias_en), .ch_off(ch_off), .db1(db1), .db2(db2)
    );

    task automatic expect_val(input string tag, input int sel, input logic [7:0] exp);
        exp_t e;
        e.tag = tag; e.sel = sel; e.exp = exp;
        q.push_back(e);
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_read();
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
    endtask

    // Monitor: pops expected items and compares away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                logic [7:0] act;
                e = q.pop_front();
                case (e.sel)
                    S_DB1:   act = db1;
                    S_DB2:   act = db2;
                    S_PULSE: act = {7'b0, pulse_en};
                    S_BIAS:  act = {7'b0, bias_en};
                    default: act = {6'b0, ch_off};
                endcase
                n_checks++;
                if (act !== e.exp) begin
                    n_fails++;
                    $display("FAIL %s: actual 0x%02h expected 0x%02h", e.tag, act, e.exp);
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_fails++;
                $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(1);
        expect_val("R1 db1", S_DB1, 8'h00);
        expect_val("R1 db2", S_DB2, 8'h00);
        expect_val("R1 pulse", S_PULSE, 8'h0);
        expect_val("R1 bias", S_BIAS, 8'h0);
        expect_val("R1 ch_off", S_OFF, 8'h0);

        // Turn-on window: ch0 ground+supply+open, ch1 open only
        diag_en = 1'b1;
        f_gnd = 2'b01; f_vs = 2'b01; f_open = 2'b11;
        amp_on = 1'b1;
        wait_cyc(5);
        expect_val("R3 pulse during window", S_PULSE, 8'h1);
        expect_val("R3 unbiased during window", S_BIAS, 8'h0);
        wait_cyc(40);
        expect_val("R3 pulse ended", S_PULSE, 8'h0);
        expect_val("R3 biased after window", S_BIAS, 8'h1);
        expect_val("R5 R2 ch0 ground wins", S_DB1, 8'h41);
        expect_val("R2 ch1 open load", S_DB2, 8'h04);
        f_gnd = '0; f_vs = '0; f_open = '0;
        wait_cyc(2);
        bus_read();
        wait_cyc(1);
        expect_val("R9 read clears done, old data kept", S_DB1, 8'h01);

        // Glitch on ch1 protection
        f_scp = 2'b10;
        wait_cyc(2);
        f_scp = 2'b00;
        wait_cyc(1);
        expect_val("R6 channel shut during filter", S_OFF, 8'h2);
        wait_cyc(30);
        expect_val("R6 channel resumed", S_OFF, 8'h0);
        expect_val("R6 bytes unchanged", S_DB2, 8'h04);

        // Persistent overload on ch1 with supply and shorted load
        f_scp = 2'b10; f_vs = 2'b10; f_sload = 2'b10;
        wait_cyc(70);
        expect_val("R7 R5 permanent result", S_DB2, 8'h12);
        expect_val("R9 done after permanent", S_DB1, 8'h41);
        expect_val("R7 restart mode holds shutdown", S_OFF, 8'h2);
        f_scp = '0; f_vs = '0; f_sload = '0;
        wait_cyc(10);
        expect_val("R8 restart releases", S_OFF, 8'h0);

        // Disarmed: overload on ch0 must not run a diagnostic window
        f_scp = 2'b01; f_gnd = 2'b01;
        wait_cyc(70);
        expect_val("R8 R9 disarmed no capture", S_DB1, 8'h41);
        expect_val("R8 disarmed shut", S_OFF, 8'h1);
        f_scp = '0; f_gnd = '0;
        wait_cyc(10);
        expect_val("R8 disarmed release", S_OFF, 8'h0);

        // Diagnostics disabled: restart mode only
        bus_read();
        diag_en = 1'b0;
        f_scp = 2'b01; f_gnd = 2'b01;
        wait_cyc(70);
        expect_val("R8 disabled no capture", S_DB1, 8'h01);
        expect_val("R8 disabled shut", S_OFF, 8'h1);
        f_scp = '0; f_gnd = '0;
        wait_cyc(10);
        expect_val("R8 disabled release", S_OFF, 8'h0);

        // Offset window with a one-cycle dropout on ch1
        f_ofs = 2'b11;
        offset_en = 1'b1;
        wait_cyc(3);
        expect_val("R11 offset active flag", S_DB2, 8'h92);
        wait_cyc(20);
        f_ofs = 2'b01;
        wait_cyc(1);
        f_ofs = 2'b11;
        wait_cyc(20);
        bus_read();
        wait_cyc(2);
        expect_val("R11 ch0 offset captured", S_DB1, 8'h05);
        expect_val("R10 ch1 dropout not reported", S_DB2, 8'h92);

        // Cancelled window
        wait_cyc(10);
        f_scp = 2'b10;
        wait_cyc(1);
        f_scp = 2'b00;
        wait_cyc(20);
        bus_read();
        wait_cyc(2);
        expect_val("R12 cancelled window ch0", S_DB1, 8'h01);
        expect_val("R12 cancelled window ch1", S_DB2, 8'h92);

        // Clean window
        wait_cyc(30);
        bus_read();
        wait_cyc(2);
        expect_val("R11 clean window ch0", S_DB1, 8'h05);
        expect_val("R11 clean window ch1", S_DB2, 8'h96);
        offset_en = 1'b0;
        f_ofs = '0;
        wait_cyc(3);
        expect_val("R11 offset inactive", S_DB2, 8'h16);

        therm_warn = 1'b1;
        wait_cyc(3);
        expect_val("R13 thermal bit", S_DB1, 8'h85);
        therm_warn = 1'b0;
        wait_cyc(3);
        expect_val("R13 thermal cleared", S_DB1, 8'h05);

        amp_on = 1'b0;
        wait_cyc(3);
        expect_val("R14 standby bias", S_BIAS, 8'h0);
        expect_val("R14 standby pulse", S_PULSE, 8'h0);

        amp_on = 1'b1;
        wait_cyc(3);
        expect_val("R4 no pulse without diag", S_PULSE, 8'h0);
        expect_val("R4 direct bias", S_BIAS, 8'h1);
        amp_on = 1'b0;
        wait_cyc(3);

        // Aborted turn-on window
        diag_en = 1'b1;
        f_gnd = 2'b11;
        amp_on = 1'b1;
        wait_cyc(5);
        expect_val("R3 armed turn-on pulse", S_PULSE, 8'h1);
        amp_on = 1'b0;
        wait_cyc(3);
        expect_val("R14 abort pulse off", S_PULSE, 8'h0);
        expect_val("R14 abort no capture", S_DB1, 8'h05);
        expect_val("R14 abort no capture ch1", S_DB2, 8'h16);
        f_gnd = '0;
        wait_cyc(3);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule